// File: doc/BRIEF.md
# Trace Cache Hit and Next-Fetch Selection

This block decides whether one stored trace-cache line can feed the front end for the current fetch address, and where fetch goes next. Each line describes a trace as several basic blocks joined by branches. For every branch it records the direction that was followed when the trace was built. It also keeps an address tag, a branch count, a flag that says whether the final block ends in a branch, a fall-through address and a taken-target address. Up to `MAX_BR` direction predictions arrive in the same cycle. The predictor derives them from global history alone, and slot i predicts the i-th branch of the trace.

The block compares the fetch address with the tag. It then walks the internal branches in trace order and stops at the first one whose predicted direction differs from the recorded one. The line is a hit only when the tag matches and every internal branch agrees. On a hit, fetch continues at the taken target if the terminal branch is predicted taken, and at the fall-through address otherwise. On any miss, the block raises a request that hands the fetch address to the instruction cache. The results are registered, so they appear one cycle after the inputs are sampled.

Top module: `tc_hit_next`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `out_valid`, `out_hit`, `out_ic_req`, `out_blocks`, `out_next_addr` and `out_ic_addr` are all zero.
- R2: Inputs are sampled on a rising edge when `fetch_valid` is 1, and the results appear on the outputs after that edge. When `fetch_valid` is 0 at an edge, every output is zero after it.
- R3: A hit requires `line_valid` = 1 and `fetch_addr` equal to `line_tag` (full-width compare). Without both, `out_hit` = 0 and `out_blocks` = 0.
- R4: Bit i of `pred_taken` and bit i of `line_mask` both describe the i-th branch of the trace, with bit 0 the first and 1 meaning taken. The internal branches are the first n of them. n is the effective count, less one when the line has a terminal branch. On a tag match, `out_hit` = 1 only if every internal prediction equals its mask bit.
- R5: On a tag match, `out_blocks` = 1 plus the number of leading internal branches whose prediction agrees with the mask. A fully matching line therefore gives n+1.
- R6: Prediction and mask bits at positions n and above (unused or terminal slots) do not affect `out_hit` or `out_blocks`.
- R7: On a hit whose line has a terminal branch at index n, `out_next_addr` is `line_tgt_addr` when `pred_taken[n]` = 1, and `line_fall_addr` when it is 0.
- R8: On a hit whose line has no terminal branch, `out_next_addr` is `line_fall_addr` for every value of `pred_taken`.
- R9: On a valid fetch that misses for either reason, `out_ic_req` = 1, `out_ic_addr` = the sampled `fetch_addr` and `out_next_addr` = 0. On a hit, `out_ic_req` = 0 and `out_ic_addr` = 0.
- R10: A `line_br_cnt` above `MAX_BR` is used as `MAX_BR`. A terminal flag together with an effective count of zero is treated as no terminal branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | ADDR_W | Current fetch address |
| line_valid | input | 1 | The presented line holds a trace |
| line_tag | input | ADDR_W | Start address of the stored trace |
| line_br_cnt | input | CNT_W | Number of branches recorded in the trace |
| line_mask | input | MAX_BR | Recorded branch directions, bit 0 first, 1 = taken |
| line_ends_br | input | 1 | The trace ends in a branch |
| line_fall_addr | input | ADDR_W | Address following the trace if not taken |
| line_tgt_addr | input | ADDR_W | Target of the terminal branch |
| pred_taken | input | MAX_BR | Parallel direction predictions, bit 0 first |
| out_valid | output | 1 | Registered results are valid |
| out_hit | output | 1 | Trace can be supplied |
| out_blocks | output | BLK_W | Number of matching basic blocks |
| out_next_addr | output | ADDR_W | Next fetch address on a hit, else 0 |
| out_ic_req | output | 1 | Miss: fetch from the instruction cache |
| out_ic_addr | output | ADDR_W | Address for the instruction cache on a miss |

## Verification
The risky internal state is the agreement prefix over the branch slots and the derived count of internal branches. An off-by-one in either, or a terminal slot that is compared, shows up on the cycle after the sample. It can appear as a wrong `out_blocks` or as a hit and instruction-cache request that flip between the two. A terminal index that points at the wrong slot appears one cycle later as the wrong choice between target and fall-through. The random stimulus leans heavily toward tag matches and agreeing masks, so that deep prefixes and terminal selection are reached often. Directed cases cover count clamping, an empty trace and unused slots.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
   // Source of the registered next-fetch address
   typedef enum logic [1:0] {
      NXT_NONE = 2'd0,
      NXT_FALL = 2'd1,
      NXT_TGT  = 2'd2
   } nxt_src_e;

   // Width needed to hold values 0..n
   function automatic int unsigned cnt_bits(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction
endpackage

// File: rtl/tc_line_decode.sv
`timescale 1ns/1ps
module tc_line_decode #(
   parameter int unsigned MAX_BR = 3,
   parameter int unsigned CNT_W  = 3
) (
   input  logic [CNT_W-1:0] br_cnt,
   input  logic             ends_br,
   output logic [CNT_W-1:0] cnt_eff,
   output logic             has_term,
   output logic [CNT_W-1:0] n_int,
   output logic [CNT_W-1:0] term_idx
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BR);

   // Clamp the stored count to the number of prediction slots
   always_comb begin
      cnt_eff  = (br_cnt > CNT_MAX) ? CNT_MAX : br_cnt;
      has_term = ends_br && (cnt_eff != '0);
      n_int    = has_term ? cnt_eff - CNT_W'(1) : cnt_eff;
      term_idx = has_term ? cnt_eff - CNT_W'(1) : '0;
   end
endmodule

// File: rtl/tc_slot_chain.sv
`timescale 1ns/1ps
module tc_slot_chain #(
   parameter int unsigned MAX_BR = 3,
   parameter int unsigned CNT_W  = 3
) (
   input  logic [CNT_W-1:0]  n_int,
   input  logic [MAX_BR-1:0] mask,
   input  logic [MAX_BR-1:0] pred,
   output logic [CNT_W-1:0]  agree_len,
   output logic              all_agree
);
   logic [MAX_BR-1:0] slot_used;
   logic [MAX_BR-1:0] slot_ok;
   logic [MAX_BR:0]   prefix;

   assign prefix[0] = 1'b1;

   // One comparator per prediction slot; the prefix stops at the first disagreement
   for (genvar i = 0; i < MAX_BR; i++) begin : g_slot
      assign slot_used[i]  = (CNT_W'(i) < n_int);
      assign slot_ok[i]    = !slot_used[i] || (pred[i] == mask[i]);
      assign prefix[i+1]   = prefix[i] && slot_ok[i];
   end

   always_comb begin
      agree_len = '0;
      for (int k = 0; k < MAX_BR; k++) begin
         if (slot_used[k] && prefix[k+1]) agree_len = agree_len + CNT_W'(1);
      end
   end

   assign all_agree = prefix[MAX_BR];
endmodule

// File: rtl/tc_next_sel.sv
`timescale 1ns/1ps
module tc_next_sel
   import tc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned MAX_BR    = 3,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned SEL_STYLE = 0   // 0: indexed select, 1: one-hot and-or
) (
   input  logic              hit,
   input  logic              has_term,
   input  logic [CNT_W-1:0]  term_idx,
   input  logic [MAX_BR-1:0] pred,
   input  logic [ADDR_W-1:0] fall_addr,
   input  logic [ADDR_W-1:0] tgt_addr,
   output logic [ADDR_W-1:0] next_addr,
   output nxt_src_e          src
);
   logic term_taken;

   if (SEL_STYLE == 0) begin : g_idx
      always_comb begin
         term_taken = 1'b0;
         for (int k = 0; k < MAX_BR; k++) begin
            if (term_idx == CNT_W'(k)) term_taken = pred[k];
         end
      end
   end else begin : g_onehot
      logic [MAX_BR-1:0] sel_oh;
      for (genvar i = 0; i < MAX_BR; i++) begin : g_dec
         assign sel_oh[i] = (term_idx == CNT_W'(i));
      end
      assign term_taken = |(sel_oh & pred);
   end

   always_comb begin
      if (!hit)                        src = NXT_NONE;
      else if (has_term && term_taken) src = NXT_TGT;
      else                             src = NXT_FALL;
      unique case (src)
         NXT_TGT:  next_addr = tgt_addr;
         NXT_FALL: next_addr = fall_addr;
         default:  next_addr = '0;
      endcase
   end
endmodule

// File: rtl/tc_hit_next.sv
`timescale 1ns/1ps
module tc_hit_next
   import tc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned MAX_BR    = 3,
   parameter int unsigned CNT_W     = 3,
   parameter int unsigned SEL_STYLE = 0,
   localparam int unsigned BLK_W    = cnt_bits(MAX_BR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              line_valid,
   input  logic [ADDR_W-1:0] line_tag,
   input  logic [CNT_W-1:0]  line_br_cnt,
   input  logic [MAX_BR-1:0] line_mask,
   input  logic              line_ends_br,
   input  logic [ADDR_W-1:0] line_fall_addr,
   input  logic [ADDR_W-1:0] line_tgt_addr,
   input  logic [MAX_BR-1:0] pred_taken,
   output logic              out_valid,
   output logic              out_hit,
   output logic [BLK_W-1:0]  out_blocks,
   output logic [ADDR_W-1:0] out_next_addr,
   output logic              out_ic_req,
   output logic [ADDR_W-1:0] out_ic_addr
);
   // Elaboration-time parameter checks
   if (MAX_BR < 1 || MAX_BR > 8) begin : g_bad_maxbr
      $error("tc_hit_next: MAX_BR must be 1..8");
   end
   if (CNT_W < cnt_bits(MAX_BR)) begin : g_bad_cntw
      $error("tc_hit_next: CNT_W too narrow for MAX_BR");
   end
   if (ADDR_W < 2) begin : g_bad_addrw
      $error("tc_hit_next: ADDR_W must be at least 2");
   end
   if (SEL_STYLE > 1) begin : g_bad_style
      $error("tc_hit_next: SEL_STYLE must be 0 or 1");
   end

   logic [CNT_W-1:0]  cnt_eff, n_int, term_idx, agree_len;
   logic              has_term, all_agree, tag_hit, hit_c;
   logic [ADDR_W-1:0] next_c;
   nxt_src_e          src_c;

   tc_line_decode #(.MAX_BR(MAX_BR), .CNT_W(CNT_W)) u_dec (
      .br_cnt   (line_br_cnt),
      .ends_br  (line_ends_br),
      .cnt_eff  (cnt_eff),
      .has_term (has_term),
      .n_int    (n_int),
      .term_idx (term_idx)
   );

   tc_slot_chain #(.MAX_BR(MAX_BR), .CNT_W(CNT_W)) u_chain (
      .n_int     (n_int),
      .mask      (line_mask),
      .pred      (pred_taken),
      .agree_len (agree_len),
      .all_agree (all_agree)
   );

   assign tag_hit = line_valid && (fetch_addr == line_tag);
   assign hit_c   = tag_hit && all_agree;

   tc_next_sel #(
      .ADDR_W(ADDR_W), .MAX_BR(MAX_BR), .CNT_W(CNT_W), .SEL_STYLE(SEL_STYLE)
   ) u_sel (
      .hit       (hit_c),
      .has_term  (has_term),
      .term_idx  (term_idx),
      .pred      (pred_taken),
      .fall_addr (line_fall_addr),
      .tgt_addr  (line_tgt_addr),
      .next_addr (next_c),
      .src       (src_c)
   );

   // Output stage
   always_ff @(posedge clk) begin
      if (!rst_n || !fetch_valid) begin
         out_valid     <= 1'b0;
         out_hit       <= 1'b0;
         out_blocks    <= '0;
         out_next_addr <= '0;
         out_ic_req    <= 1'b0;
         out_ic_addr   <= '0;
      end else begin
         out_valid     <= 1'b1;
         out_hit       <= hit_c;
         out_blocks    <= tag_hit ? BLK_W'(agree_len) + BLK_W'(1) : '0;
         out_next_addr <= next_c;
         out_ic_req    <= !hit_c;
         out_ic_addr   <= hit_c ? '0 : fetch_addr;
      end
   end

   // R2: a sampled fetch produces a valid result on the next cycle
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> out_valid);

   // R2: idle cycles leave the outputs quiet
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |=> (!out_valid && !out_hit && !out_ic_req));

   // R3: no hit and no blocks without a valid tag match
   a_r3_tag_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !(line_valid && fetch_addr == line_tag))
      |=> (!out_hit && out_blocks == '0));

   // R5: a hit always supplies at least the first block
   a_r5_blocks_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> (out_blocks != '0));

   // R8: without a terminal branch, a hit continues at the fall-through address
   a_r8_fall_no_term: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && !line_ends_br)
      |=> (!out_hit || out_next_addr == $past(line_fall_addr)));

   // R9: every valid fetch is either a hit or an instruction-cache request
   a_r9_hit_xor_req: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> (out_hit != out_ic_req));

   // R9: a miss forwards the sampled fetch address
   a_r9_ic_addr: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> (!out_ic_req || out_ic_addr == $past(fetch_addr)));
endmodule

// File: tb/tc_hit_next_tb.sv
`timescale 1ns/1ps
module tc_hit_next_tb;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned MAX_BR = 3;
   localparam int unsigned CNT_W  = 3;
   localparam int unsigned BLK_W  = 3;
   localparam int unsigned NRAND  = 3000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              fetch_valid;
   logic [ADDR_W-1:0] fetch_addr;
   logic              line_valid;
   logic [ADDR_W-1:0] line_tag;
   logic [CNT_W-1:0]  line_br_cnt;
   logic [MAX_BR-1:0] line_mask;
   logic              line_ends_br;
   logic [ADDR_W-1:0] line_fall_addr;
   logic [ADDR_W-1:0] line_tgt_addr;
   logic [MAX_BR-1:0] pred_taken;
   logic              out_valid, out_hit, out_ic_req;
   logic [BLK_W-1:0]  out_blocks;
   logic [ADDR_W-1:0] out_next_addr, out_ic_addr;

   int checks = 0;
   int errors = 0;

   // Expected results of the last drive
   logic              e_valid, e_hit, e_req;
   logic [BLK_W-1:0]  e_blocks;
   logic [ADDR_W-1:0] e_next, e_icaddr;

   always #4 clk = ~clk;

   tc_hit_next #(.ADDR_W(ADDR_W), .MAX_BR(MAX_BR), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .line_valid(line_valid), .line_tag(line_tag), .line_br_cnt(line_br_cnt),
      .line_mask(line_mask), .line_ends_br(line_ends_br),
      .line_fall_addr(line_fall_addr), .line_tgt_addr(line_tgt_addr),
      .pred_taken(pred_taken), .out_valid(out_valid), .out_hit(out_hit),
      .out_blocks(out_blocks), .out_next_addr(out_next_addr),
      .out_ic_req(out_ic_req), .out_ic_addr(out_ic_addr)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference model built from the requirement text
   task automatic compute_expected();
      int  cnt, nint, agree;
      bit  term, tmatch, ok;
      e_valid = fetch_valid;
      if (!fetch_valid) begin
         e_hit = 0; e_req = 0; e_blocks = 0; e_next = 0; e_icaddr = 0;
         return;
      end
      cnt  = (int'(line_br_cnt) > MAX_BR) ? MAX_BR : int'(line_br_cnt);   // R10
      term = line_ends_br && (cnt > 0);
      nint = term ? cnt - 1 : cnt;
      tmatch = line_valid && (fetch_addr == line_tag);                      // R3
      agree = 0; ok = 1;
      for (int i = 0; i < nint; i++) begin                                  // R4, R6
         if (ok && pred_taken[i] == line_mask[i]) agree++;
         else ok = 0;
      end
      e_hit    = tmatch && ok;
      e_blocks = tmatch ? BLK_W'(agree + 1) : '0;                           // R5
      e_req    = !e_hit;                                                    // R9
      e_icaddr = e_hit ? '0 : fetch_addr;
      if (!e_hit)                        e_next = '0;
      else if (term && pred_taken[nint]) e_next = line_tgt_addr;            // R7
      else                               e_next = line_fall_addr;           // R8
   endtask

   task automatic check_all(input string req);
      check(req, "out_valid",  64'(out_valid),     64'(e_valid));
      check(req, "out_hit",    64'(out_hit),       64'(e_hit));
      check(req, "out_blocks", 64'(out_blocks),    64'(e_blocks));
      check(req, "out_next",   64'(out_next_addr), 64'(e_next));
      check(req, "out_ic_req", 64'(out_ic_req),    64'(e_req));
      check(req, "out_ic_addr",64'(out_ic_addr),   64'(e_icaddr));
   endtask

   // Drive at a falling edge, let one rising edge register, check at the next falling edge
   task automatic apply(input string req, input bit fv, input logic [ADDR_W-1:0] fa,
                        input bit lv, input logic [ADDR_W-1:0] tag,
                        input logic [CNT_W-1:0] cnt, input logic [MAX_BR-1:0] msk,
                        input bit ends, input logic [ADDR_W-1:0] fall,
                        input logic [ADDR_W-1:0] tgt, input logic [MAX_BR-1:0] prd);
      fetch_valid = fv; fetch_addr = fa; line_valid = lv; line_tag = tag;
      line_br_cnt = cnt; line_mask = msk; line_ends_br = ends;
      line_fall_addr = fall; line_tgt_addr = tgt; pred_taken = prd;
      compute_expected();
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed = 32'd20240517;
      logic [ADDR_W-1:0] a;
      void'($urandom(seed));
      rst_n = 0; fetch_valid = 1; fetch_addr = 32'h100; line_valid = 1;
      line_tag = 32'h100; line_br_cnt = 0; line_mask = 0; line_ends_br = 0;
      line_fall_addr = 32'h200; line_tgt_addr = 32'h300; pred_taken = 0;
      repeat (3) @(negedge clk);
      // R1: outputs held at zero in reset even with a would-be hit on the inputs
      e_valid = 0; e_hit = 0; e_req = 0; e_blocks = 0; e_next = 0; e_icaddr = 0;
      check_all("R1");
      fetch_valid = 0;
      rst_n = 1;
      @(negedge clk);
      check_all("R1");

      // R2: idle cycle
      apply("R2", 0, 32'h40, 1, 32'h40, 3'd2, 3'b011, 1, 32'h1, 32'h2, 3'b011);
      // R3: tag mismatch, and valid low with a matching tag
      apply("R3", 1, 32'h1000, 1, 32'h1004, 3'd1, 3'b001, 0, 32'hA, 32'hB, 3'b001);
      apply("R3", 1, 32'h2000, 0, 32'h2000, 3'd0, 3'b000, 0, 32'hA, 32'hB, 3'b000);
      // R4/R5: three internal branches, all agree -> 4 blocks, fall-through (R8)
      apply("R5", 1, 32'h3000, 1, 32'h3000, 3'd3, 3'b101, 0, 32'h3100, 32'h3200, 3'b101);
      // R4/R5: disagreement at slot 1 -> miss, 2 blocks, cache request (R9)
      apply("R4", 1, 32'h3000, 1, 32'h3000, 3'd3, 3'b101, 0, 32'h3100, 32'h3200, 3'b111);
      // R7: terminal branch at slot 2 predicted taken -> target
      apply("R7", 1, 32'h4000, 1, 32'h4000, 3'd3, 3'b011, 1, 32'h4100, 32'h4200, 3'b111);
      // R7: same line, terminal predicted not taken -> fall-through
      apply("R7", 1, 32'h4000, 1, 32'h4000, 3'd3, 3'b111, 1, 32'h4100, 32'h4200, 3'b011);
      // R6: one internal branch, garbage in unused slots
      apply("R6", 1, 32'h5000, 1, 32'h5000, 3'd1, 3'b110, 0, 32'h5100, 32'h5200, 3'b000);
      // R8: no terminal branch, every prediction taken
      apply("R8", 1, 32'h6000, 1, 32'h6000, 3'd2, 3'b011, 0, 32'h6100, 32'h6200, 3'b111);
      // R10: count above MAX_BR clamps to 3, terminal at slot 2
      apply("R10", 1, 32'h7000, 1, 32'h7000, 3'd7, 3'b011, 1, 32'h7100, 32'h7200, 3'b111);
      // R10: terminal flag with zero count -> single block, fall-through
      apply("R10", 1, 32'h8000, 1, 32'h8000, 3'd0, 3'b111, 1, 32'h8100, 32'h8200, 3'b111);
      // R9: miss at first internal branch
      apply("R9", 1, 32'h9000, 1, 32'h9000, 3'd2, 3'b000, 1, 32'h9100, 32'h9200, 3'b001);

      // Random mix, biased toward tag matches and agreeing directions
      for (int n = 0; n < NRAND; n++) begin
         logic [MAX_BR-1:0] m, p;
         logic [CNT_W-1:0]  c;
         a = $urandom & 32'hFFFF_FFFC;
         m = MAX_BR'($urandom);
         p = ($urandom_range(0, 3) != 0) ? m : MAX_BR'($urandom);
         c = CNT_W'($urandom_range(0, 7));
         apply("R4", ($urandom_range(0, 9) != 0), a, ($urandom_range(0, 7) != 0),
               ($urandom_range(0, 4) != 0) ? a : (a ^ 32'h10),
               c, m, 1'($urandom), $urandom, $urandom, p);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule